// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Bank with Interrupt Detection

The block controls sixteen general-purpose pins through a small register bus. The bus is word addressed and uses byte offsets. For each pin, software sets whether the pin drives or receives, the value it drives, and whether a peripheral takes the pin over. The block also sends an interrupt for a pin when the input goes through an edge or sits at a level. Software chooses the edge or level and its polarity for each pin. Detections are held in a sticky status register, and software clears them by writing ones. One interrupt line carries the OR of every status bit that is not masked.

Two conditions at the system level can take over the pin outputs. The battery-fault condition has priority, and each output pin then drives its battery-fault value. The sleep condition is next. When sleep mode is active and automatic sleep is enabled, each output pin drives its sleep value. While sleep is in effect, a second mask can also block the interrupts of chosen pins. Inputs pass through a two-flop synchronizer. The synchronized value can be read back live, and the edge and level detectors use it.

Top module: `gpio_bank16`

## Requirements
- R1: After reset, the interrupt mask reads 0xFFFF (all pins blocked). Every other writable register reads 0. irq is 0 and pin_oe is 0.
- R2: These registers are read/write, at byte offsets: mask 0x00, direction 0x04, output 0x08, trigger type 0x0C, edge polarity 0x10, level polarity 0x14, sleep mask 0x18, sleep output 0x1C, battery-fault output 0x20, alternate function 0x28 and sleep config 0x2C. A write through reg_wr takes effect at the clock edge. Reads are combinational on reg_rdata. A write to offset 0x30 is ignored, and an unmapped offset such as 0x34 reads 0.
- R3: Offset 0x30 reads the pin inputs after a two-flop synchronizer. A change on pin_in is not visible one clock later and is visible two clocks later.
- R4: In normal operation (no battery fault, sleep not in effect, alternate bit 0), pin_oe equals the direction bit (1 = output, 0 = input) and pin_out equals the output bit.
- R5: An alternate-function bit of 1 makes that pin take pin_out from alt_out and pin_oe from alt_oe.
- R6: Sleep is in effect when sleep_mode is 1 and bit 1 of the sleep config register is 1. While it is in effect, pin_out takes the sleep-output bit, pin_oe takes the direction bit, and the alternate-function selection is overridden. With config bit 1 at 0, sleep_mode has no effect on the pins.
- R7: While batt_fault is 1, pin_out takes the battery-fault output bit and pin_oe takes the direction bit, above sleep and above alternate function.
- R8: A trigger-type bit of 1 selects edge detection. In edge mode, an edge-polarity bit of 1 detects rising edges and 0 detects falling edges. The status bit at offset 0x24 reads 1 three clocks after the pin_in change and not after two.
- R9: A trigger-type bit of 0 selects level detection. In level mode, a level-polarity bit of 1 detects a high input and 0 detects a low input. While the level persists, a write-1 clear does not leave the status bit at 0.
- R10: Writing 1 to a status bit at offset 0x24 clears it and writing 0 leaves it unchanged. Once the pin has settled, the bit stays clear.
- R11: irq is the OR of the status bits whose mask bit is 0. While sleep is in effect, a sleep-mask bit of 1 also blocks that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| pin_in | input | 16 | Pin input levels |
| alt_out | input | 16 | Peripheral output values |
| alt_oe | input | 16 | Peripheral output enables |
| sleep_mode | input | 1 | System sleep condition |
| batt_fault | input | 1 | Battery-fault condition |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The output mux is tried with random combinations of direction, output, alternate-function, sleep and battery-fault settings. These separate the four priority levels from one another, and they separate sleep that is enabled from sleep that is only requested. Edge detection is tried with random input changes under random polarity. This tells rising detection apart from falling detection, and both apart from a pin that does not change. Directed cases cover the synchronizer latency and the exact cycle in which status sets. They also cover a level that persists and defeats a clear, a write of 0 that leaves status alone, and the sleep mask that blocks irq.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 6;
  localparam int SLEEP_AUTO_BIT = 1;

  localparam logic [ADDR_W-1:0] OFF_MASK  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR   = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_OUT   = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_TRIG  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_EPOL  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_LPOL  = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_SMASK = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_SOUT  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_BOUT  = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 6'h24;
  localparam logic [ADDR_W-1:0] OFF_ALT   = 6'h28;
  localparam logic [ADDR_W-1:0] OFF_SCFG  = 6'h2C;
  localparam logic [ADDR_W-1:0] OFF_PIN   = 6'h30;

  typedef enum logic [3:0] {
    RS_MASK, RS_DIR, RS_OUT, RS_TRIG, RS_EPOL, RS_LPOL, RS_SMASK,
    RS_SOUT, RS_BOUT, RS_STAT, RS_ALT, RS_SCFG, RS_PIN, RS_NONE
  } rsel_t;

  function automatic rsel_t decode_off(input logic [ADDR_W-1:0] a);
    rsel_t s;
    case (a)
      OFF_MASK:  s = RS_MASK;
      OFF_DIR:   s = RS_DIR;
      OFF_OUT:   s = RS_OUT;
      OFF_TRIG:  s = RS_TRIG;
      OFF_EPOL:  s = RS_EPOL;
      OFF_LPOL:  s = RS_LPOL;
      OFF_SMASK: s = RS_SMASK;
      OFF_SOUT:  s = RS_SOUT;
      OFF_BOUT:  s = RS_BOUT;
      OFF_STAT:  s = RS_STAT;
      OFF_ALT:   s = RS_ALT;
      OFF_SCFG:  s = RS_SCFG;
      OFF_PIN:   s = RS_PIN;
      default:   s = RS_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      status_q,
  input  logic [N-1:0]      pin_sync,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      out_q,
  output logic [N-1:0]      trig_q,
  output logic [N-1:0]      epol_q,
  output logic [N-1:0]      lpol_q,
  output logic [N-1:0]      smask_q,
  output logic [N-1:0]      sout_q,
  output logic [N-1:0]      bout_q,
  output logic [N-1:0]      alt_q,
  output logic [N-1:0]      scfg_q,
  output logic [N-1:0]      clr_vec,
  output logic [N-1:0]      rdata
);
  rsel_t sel;
  assign sel = decode_off(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      dir_q   <= '0;
      out_q   <= '0;
      trig_q  <= '0;
      epol_q  <= '0;
      lpol_q  <= '0;
      smask_q <= '0;
      sout_q  <= '0;
      bout_q  <= '0;
      alt_q   <= '0;
      scfg_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        RS_MASK:  mask_q  <= wdata;
        RS_DIR:   dir_q   <= wdata;
        RS_OUT:   out_q   <= wdata;
        RS_TRIG:  trig_q  <= wdata;
        RS_EPOL:  epol_q  <= wdata;
        RS_LPOL:  lpol_q  <= wdata;
        RS_SMASK: smask_q <= wdata;
        RS_SOUT:  sout_q  <= wdata;
        RS_BOUT:  bout_q  <= wdata;
        RS_ALT:   alt_q   <= wdata;
        RS_SCFG:  scfg_q  <= wdata;
        default:  ;
      endcase
    end
  end

  assign clr_vec = (wr_en && sel == RS_STAT) ? wdata : '0;

  always_comb begin
    case (sel)
      RS_MASK:  rdata = mask_q;
      RS_DIR:   rdata = dir_q;
      RS_OUT:   rdata = out_q;
      RS_TRIG:  rdata = trig_q;
      RS_EPOL:  rdata = epol_q;
      RS_LPOL:  rdata = lpol_q;
      RS_SMASK: rdata = smask_q;
      RS_SOUT:  rdata = sout_q;
      RS_BOUT:  rdata = bout_q;
      RS_STAT:  rdata = status_q;
      RS_ALT:   rdata = alt_q;
      RS_SCFG:  rdata = scfg_q;
      RS_PIN:   rdata = pin_sync;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] epol,
  input  logic [N-1:0] lpol,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] edge_hit,
  output logic [N-1:0] level_hit,
  output logic [N-1:0] hit,
  output logic [N-1:0] status_q
);
  logic [N-1:0] prev_q;

  function automatic logic [N-1:0] edge_fn(input logic [N-1:0] c,
                                           input logic [N-1:0] p,
                                           input logic [N-1:0] pol);
    return (pol & c & ~p) | (~pol & ~c & p);
  endfunction

  function automatic logic [N-1:0] level_fn(input logic [N-1:0] c,
                                            input logic [N-1:0] pol);
    return ~(c ^ pol);
  endfunction

  assign edge_hit  = trig & edge_fn(cur, prev_q, epol);
  assign level_hit = ~trig & level_fn(cur, lpol);
  assign hit       = edge_hit | level_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= cur;
      status_q <= (status_q & ~clr_vec) | hit;
    end
  end
endmodule

// File: rtl/gpio_outmux.sv
module gpio_outmux #(
  parameter int N = 16
) (
  input  logic [N-1:0] dir_q,
  input  logic [N-1:0] out_q,
  input  logic [N-1:0] alt_q,
  input  logic [N-1:0] alt_out,
  input  logic [N-1:0] alt_oe,
  input  logic [N-1:0] sout_q,
  input  logic [N-1:0] bout_q,
  input  logic         sleep_act,
  input  logic         batt_fault,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe
);
  function automatic logic [1:0] pick(input logic d, input logic o,
                                      input logic a, input logic ao,
                                      input logic ae, input logic so,
                                      input logic bo, input logic slp,
                                      input logic bf);
    if (bf)       return {d, bo};
    else if (slp) return {d, so};
    else if (a)   return {ae, ao};
    else          return {d, o};
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [1:0] sel;
    assign sel = pick(dir_q[i], out_q[i], alt_q[i], alt_out[i], alt_oe[i],
                      sout_q[i], bout_q[i], sleep_act, batt_fault);
    assign pin_oe[i]  = sel[1];
    assign pin_out[i] = sel[0];
  end
endmodule

// File: rtl/gpio_bank16.sv
module gpio_bank16
  import gpio_bank_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N-1:0]      reg_wdata,
  output logic [N-1:0]      reg_rdata,
  input  logic [N-1:0]      pin_in,
  input  logic [N-1:0]      alt_out,
  input  logic [N-1:0]      alt_oe,
  input  logic              sleep_mode,
  input  logic              batt_fault,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic              irq
);
  logic [N-1:0] mask_q, dir_q, out_q, trig_q, epol_q, lpol_q;
  logic [N-1:0] smask_q, sout_q, bout_q, alt_q, scfg_q;
  logic [N-1:0] clr_vec, status_q, pin_sync;
  logic [N-1:0] edge_hit, level_hit, hit, block_vec;
  logic         sleep_act;

  gpio_regfile #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .status_q(status_q), .pin_sync(pin_sync),
    .mask_q(mask_q), .dir_q(dir_q), .out_q(out_q), .trig_q(trig_q),
    .epol_q(epol_q), .lpol_q(lpol_q), .smask_q(smask_q), .sout_q(sout_q),
    .bout_q(bout_q), .alt_q(alt_q), .scfg_q(scfg_q), .clr_vec(clr_vec),
    .rdata(reg_rdata)
  );

  gpio_sync #(.N(N), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  gpio_detect #(.N(N)) u_det (
    .clk(clk), .rst_n(rst_n), .cur(pin_sync), .trig(trig_q),
    .epol(epol_q), .lpol(lpol_q), .clr_vec(clr_vec),
    .edge_hit(edge_hit), .level_hit(level_hit), .hit(hit),
    .status_q(status_q)
  );

  assign sleep_act = sleep_mode & scfg_q[SLEEP_AUTO_BIT];

  gpio_outmux #(.N(N)) u_mux (
    .dir_q(dir_q), .out_q(out_q), .alt_q(alt_q), .alt_out(alt_out),
    .alt_oe(alt_oe), .sout_q(sout_q), .bout_q(bout_q),
    .sleep_act(sleep_act), .batt_fault(batt_fault),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign block_vec = mask_q | (sleep_act ? smask_q : '0);
  assign irq       = |(status_q & ~block_vec);
endmodule

// File: rtl/gpio_bank16_chk.sv
module gpio_bank16_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] pin_in,
  input logic [N-1:0] pin_sync,
  input logic [N-1:0] status_q,
  input logic [N-1:0] clr_vec,
  input logic [N-1:0] edge_hit,
  input logic         irq,
  input logic         batt_fault,
  input logic         sleep_act,
  input logic [N-1:0] bout_q,
  input logic [N-1:0] dir_q,
  input logic [N-1:0] alt_q,
  input logic [N-1:0] pin_out,
  input logic [N-1:0] pin_oe
);
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R3: synchronizer latency of two clocks
  p_sync_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2) |-> (pin_sync == $past(pin_in, 2)));

  // R8: edge detection latches status on the next edge
  p_edge_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((status_q & $past(edge_hit)) == $past(edge_hit)));

  // R10: status bits stay set without a clearing write
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R11: interrupt only with some status present
  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|status_q));

  // R7: battery fault forces its output values
  p_batt_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    batt_fault |-> (pin_out == bout_q && pin_oe == dir_q));

  // R4: normal operation enables follow direction
  p_norm_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!batt_fault && !sleep_act && alt_q == '0) |-> (pin_oe == dir_q));
endmodule

bind gpio_bank16 gpio_bank16_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(pin_sync),
  .status_q(status_q), .clr_vec(clr_vec), .edge_hit(edge_hit), .irq(irq),
  .batt_fault(batt_fault), .sleep_act(sleep_act), .bout_q(bout_q),
  .dir_q(dir_q), .alt_q(alt_q), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/tb_gpio_bank16.sv
`timescale 1ns/1ps
module tb_gpio_bank16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] alt_out = '0;
  logic [15:0] alt_oe = '0;
  logic        sleep_mode = 1'b0;
  logic        batt_fault = 1'b0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_bank16 dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .alt_out(alt_out), .alt_oe(alt_oe), .sleep_mode(sleep_mode),
    .batt_fault(batt_fault), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=50000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_pins(
      input logic [15:0] d, input logic [15:0] o, input logic [15:0] a,
      input logic [15:0] ao, input logic [15:0] ae, input logic [15:0] so,
      input logic [15:0] bo, input logic slp_req, input logic auto_en,
      input logic bf);
    logic [15:0] eo, ee;
    for (int i = 0; i < 16; i++) begin
      if (bf) begin ee[i] = d[i]; eo[i] = bo[i]; end
      else if (slp_req && auto_en) begin ee[i] = d[i]; eo[i] = so[i]; end
      else if (a[i]) begin ee[i] = ae[i]; eo[i] = ao[i]; end
      else begin ee[i] = d[i]; eo[i] = o[i]; end
    end
    return {ee, eo};
  endfunction

  function automatic logic [15:0] exp_edges(input logic [15:0] oldv,
      input logic [15:0] newv, input logic [15:0] pol);
    logic [15:0] r;
    for (int i = 0; i < 16; i++)
      r[i] = pol[i] ? (!oldv[i] && newv[i]) : (oldv[i] && !newv[i]);
    return r;
  endfunction

  initial begin
    logic [15:0] v, rv, d, o, a, so, bo, pol, oldv, newv, m;
    logic        slp, ae_bit, bf;
    logic [5:0]  offs [11];
    logic [15:0] vals [11];
    v = $urandom(32'd20250);
    offs = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1C, 6'h20, 6'h28, 6'h2C};

    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 pin_oe", {16'd0, pin_oe}, 32'd0);
    rd(6'h00, rv); chk("R1 mask", {16'd0, rv}, 32'h0000FFFF);
    rd(6'h04, rv); chk("R1 dir", {16'd0, rv}, 32'd0);
    rd(6'h2C, rv); chk("R1 scfg", {16'd0, rv}, 32'd0);

    // R2 readback of every read/write register
    for (int k = 0; k < 11; k++) begin
      vals[k] = 16'($urandom);
      wr(offs[k], vals[k]);
    end
    for (int k = 0; k < 11; k++) begin
      rd(offs[k], rv);
      chk($sformatf("R2 readback off %h", offs[k]), {16'd0, rv}, {16'd0, vals[k]});
    end
    wr(6'h2C, 16'h0000);
    wr(6'h00, 16'hFFFF);

    // R3 synchronizer latency
    @(negedge clk); pin_in = 16'h5A5A;
    tick(1); rd(6'h30, rv); chk("R3 one clock", {16'd0, rv}, 32'd0);
    tick(1); rd(6'h30, rv); chk("R3 two clocks", {16'd0, rv}, 32'h00005A5A);
    wr(6'h30, 16'hFFFF); rd(6'h30, rv); chk("R2 pin status write ignored", {16'd0, rv}, 32'h00005A5A);
    rd(6'h34, rv); chk("R2 unmapped", {16'd0, rv}, 32'd0);

    // R4..R7 random output mux
    for (int it = 0; it < 40; it++) begin
      d = 16'($urandom); o = 16'($urandom); a = 16'($urandom);
      so = 16'($urandom); bo = 16'($urandom);
      ae_bit = 1'($urandom);
      slp = 1'($urandom); bf = ($urandom % 4) == 0;
      if (it < 4) begin a = 16'h0000; bf = 1'b0; slp = 1'b0; end
      wr(6'h04, d); wr(6'h08, o); wr(6'h28, a); wr(6'h1C, so); wr(6'h20, bo);
      wr(6'h2C, {14'd0, ae_bit, 1'b0});
      alt_out = 16'($urandom); alt_oe = 16'($urandom);
      sleep_mode = slp; batt_fault = bf;
      #1;
      v = exp_pins(d, o, a, alt_out, alt_oe, so, bo, slp, ae_bit, bf) >> 16;
      chk($sformatf("R4/R5/R6/R7 pin_oe it%0d bf=%0d slp=%0d auto=%0d", it, bf, slp, ae_bit),
          {16'd0, pin_oe}, {16'd0, v});
      v = exp_pins(d, o, a, alt_out, alt_oe, so, bo, slp, ae_bit, bf) & 32'hFFFF;
      chk($sformatf("R4/R5/R6/R7 pin_out it%0d", it), {16'd0, pin_out}, {16'd0, v});
    end
    sleep_mode = 1'b0; batt_fault = 1'b0;
    wr(6'h28, 16'h0000); wr(6'h2C, 16'h0000);

    // R8 directed edge timing: all pins edge, rising
    wr(6'h0C, 16'hFFFF); wr(6'h10, 16'hFFFF);
    @(negedge clk); pin_in = 16'h0000;
    tick(4);
    wr(6'h24, 16'hFFFF);
    rd(6'h24, rv); chk("R10 clear all", {16'd0, rv}, 32'd0);
    @(negedge clk); pin_in = 16'h0008;
    tick(2); rd(6'h24, rv); chk("R8 not yet at two", {16'd0, rv}, 32'd0);
    tick(1); rd(6'h24, rv); chk("R8 rising set at three", {16'd0, rv}, 32'h00000008);
    wr(6'h24, 16'h0000); rd(6'h24, rv); chk("R10 write zero keeps", {16'd0, rv}, 32'h00000008);
    // R11 unmask bit 3
    wr(6'h00, 16'hFFF7); chk("R11 irq unmasked", {31'd0, irq}, 32'd1);
    wr(6'h18, 16'h0008); wr(6'h2C, 16'h0002);
    @(negedge clk); sleep_mode = 1'b1; #1;
    chk("R11 sleep mask blocks", {31'd0, irq}, 32'd0);
    @(negedge clk); sleep_mode = 1'b0; #1;
    chk("R11 irq after sleep", {31'd0, irq}, 32'd1);
    wr(6'h2C, 16'h0000);
    wr(6'h24, 16'h0008); rd(6'h24, rv); chk("R10 write one clears", {16'd0, rv}, 32'd0);
    chk("R11 irq cleared", {31'd0, irq}, 32'd0);
    // falling edge
    wr(6'h10, 16'hFFF7);
    @(negedge clk); pin_in = 16'h0000;
    tick(3); rd(6'h24, rv); chk("R8 falling set", {16'd0, rv}, 32'h00000008);
    wr(6'h24, 16'hFFFF);

    // R9 level high on pin 5
    wr(6'h0C, 16'hFFDF); wr(6'h14, 16'h0020);
    tick(2); wr(6'h24, 16'hFFFF);
    rd(6'h24, rv); chk("R9 no level yet", {16'd0, rv}, 32'd0);
    @(negedge clk); pin_in = 16'h0020;
    tick(3); rd(6'h24, rv); chk("R9 level high set", {16'd0, rv}, 32'h00000020);
    wr(6'h24, 16'h0020); rd(6'h24, rv); chk("R9 level persists past clear", {16'd0, rv}, 32'h00000020);
    @(negedge clk); pin_in = 16'h0000;
    tick(4); wr(6'h24, 16'h0020); tick(2);
    rd(6'h24, rv); chk("R10 level gone stays clear", {16'd0, rv}, 32'd0);
    // level low on pin 5
    wr(6'h14, 16'h0000);
    tick(1); rd(6'h24, rv); chk("R9 level low set", {16'd0, rv}, 32'h00000020);

    // R8/R11 random edges
    wr(6'h0C, 16'hFFFF);
    oldv = pin_in;
    for (int it = 0; it < 30; it++) begin
      pol = 16'($urandom); m = 16'($urandom);
      wr(6'h10, pol); wr(6'h00, m);
      tick(4);
      wr(6'h24, 16'hFFFF);
      newv = 16'($urandom);
      @(negedge clk); pin_in = newv;
      tick(4);
      v = exp_edges(oldv, newv, pol);
      rd(6'h24, rv);
      chk($sformatf("R8 random edges it%0d", it), {16'd0, rv}, {16'd0, v});
      chk($sformatf("R11 random irq it%0d", it), {31'd0, irq}, {31'd0, |(v & ~m)});
      oldv = newv;
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule